// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block turns a bank of general-purpose input pins into interrupt requests. Each pin passes through a multi-flop synchronizer and an optional per-pin debounce filter. It is then judged by its own sensing rule: either a level that is active high or active low, or an edge that is rising or falling and is latched until software acknowledges it.

The block presents three results. A raw pending vector shows every enabled pin with an active condition. A status vector also hides pins whose mask bit is set. A single interrupt line is the OR of the status vector. A register wrapper around the block holds the configuration vectors and turns a write of the acknowledge register into a one-cycle pulse on the clear vector. Detection keeps running on masked pins, so unmasking a pin that already saw an event shows that event at once. Edge history is kept apart from the polarity setting, so changing the selected direction never loses a later edge in the new direction.

Top module: `pin_irq_unit`

## Requirements
- R1: After reset, `raw_pend`, `stat` and `irq` are all zero.
- R2: With `cfg_edge[i]`=0 (level sensing), `raw_pend[i]` is 1 while the qualified pin equals `cfg_pol[i]` (1 = active high, 0 = active low). It is not latched, and a 1 on `eoi_clr[i]` has no effect on it.
- R3: With `cfg_edge[i]`=1 (edge sensing), a rising edge (`cfg_pol[i]`=1) or a falling edge (`cfg_pol[i]`=0) of the qualified pin sets a latched event. `raw_pend[i]` then stays 1 after the pin returns, and an edge in the other direction does not set it.
- R4: A 1 on `eoi_clr[i]` for one cycle clears the latched edge event of pin i only. An all-ones clear vector clears every latched edge.
- R5: If an edge is detected in the same cycle that `eoi_clr[i]` is 1, the event stays latched.
- R6: While `cfg_en[i]`=0, `raw_pend[i]` is 0 and the latched event of pin i is cleared. Re-enabling the pin does not bring back an old event.
- R7: With `cfg_mask[i]`=1, `stat[i]` is 0 and pin i cannot drive `irq`, but edge detection still runs and `raw_pend[i]` still reports the event.
- R8: `stat` equals `raw_pend & cfg_en & ~cfg_mask`, and `irq` is 1 exactly when some `stat` bit is 1.
- R9: Changing `cfg_pol[i]` while the pin is enabled does not lose a later edge in the newly selected direction.
- R10: With `cfg_deb[i]`=1, a pin change is accepted only when the synchronized value agrees at two consecutive `deb_tick` strobes. A pulse seen by only one strobe is ignored.
- R11: With debounce off, a level change on `pin_raw[i]` that is driven before clock edge 1 reaches `raw_pend[i]` after clock edge 2 (two synchronizer flops) and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_raw | input | NPINS | Asynchronous pin values |
| deb_tick | input | 1 | Slow strobe that samples the debounce filter |
| cfg_en | input | NPINS | Per-pin interrupt enable |
| cfg_mask | input | NPINS | Per-pin mask (1 = hidden from status and irq) |
| cfg_edge | input | NPINS | Sensing type (1 = edge, 0 = level) |
| cfg_pol | input | NPINS | Polarity (1 = rising/high, 0 = falling/low) |
| cfg_deb | input | NPINS | Per-pin debounce enable |
| eoi_clr | input | NPINS | Write-one-to-clear pulse for latched edges |
| raw_pend | output | NPINS | Pending events of enabled pins, before masking |
| stat | output | NPINS | Pending events after enable and mask |
| irq | output | 1 | OR of all status bits |

## Verification
The bound checker tests on every cycle that status never shows a masked or non-pending pin, that the interrupt line matches the status vector, that an edge event never survives a cycle in which its pin was disabled, and that a latched edge stays pending until an acknowledge, a disable or a change of sensing type. The bench scenarios cover what needs longer histories. These are the sensing direction and the polarity-switch case, the same-cycle race between set and acknowledge, selective and full acknowledge, the exact synchronizer latency, and the rejection of a short debounce glitch. Random configurations and pin activity are compared against a reference model in the bench.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
   // Edge hit in the selected direction: pol=1 rising, pol=0 falling
   function automatic logic pirq_edge_hit(input logic cur, input logic prev, input logic pol);
      return pol ? (cur & ~prev) : (~cur & prev);
   endfunction

   // Level active when the pin equals the polarity bit
   function automatic logic pirq_level_hit(input logic cur, input logic pol);
      return ~(cur ^ pol);
   endfunction
endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg[k] <= '0;
      end else begin
         stg[0] <= d;
         for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/pirq_debounce.sv
module pirq_debounce #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] filt
);
   logic [WIDTH-1:0] smp;
   logic [WIDTH-1:0] agree;

   assign agree = ~(d ^ smp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp  <= '0;
         filt <= '0;
      end else if (tick) begin
         smp  <= d;
         filt <= (filt & ~agree) | (d & agree);
      end
   end
endmodule

// File: rtl/pirq_cell.sv
module pirq_cell
   import pirq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic q,
   input  logic en,
   input  logic edge_mode,
   input  logic pol,
   input  logic eoi,
   output logic pend
);
   logic q_d;
   logic latch_q;
   logic hit;
   logic latch_nxt;

   assign hit       = pirq_edge_hit(q, q_d, pol);
   assign latch_nxt = en & edge_mode & (hit | (latch_q & ~eoi));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_d     <= 1'b0;
         latch_q <= 1'b0;
      end else begin
         q_d     <= q;
         latch_q <= latch_nxt;
      end
   end

   assign pend = en & (edge_mode ? latch_q : pirq_level_hit(q, pol));
endmodule

// File: rtl/pin_irq_unit.sv
module pin_irq_unit #(
   parameter int NPINS        = 32,
   parameter int SYNC_STAGES  = 2,
   parameter bit HAS_DEBOUNCE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pin_raw,
   input  logic             deb_tick,
   input  logic [NPINS-1:0] cfg_en,
   input  logic [NPINS-1:0] cfg_mask,
   input  logic [NPINS-1:0] cfg_edge,
   input  logic [NPINS-1:0] cfg_pol,
   input  logic [NPINS-1:0] cfg_deb,
   input  logic [NPINS-1:0] eoi_clr,
   output logic [NPINS-1:0] raw_pend,
   output logic [NPINS-1:0] stat,
   output logic             irq
);
   localparam int LastPin = NPINS - 1;

   if (NPINS < 1 || NPINS > 32) begin : g_bad_npins
      $error("pin_irq_unit: NPINS must lie in 1..32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pin_irq_unit: SYNC_STAGES must be at least 2");
   end

   logic [LastPin:0] pin_sync;
   logic [LastPin:0] pin_qual;

   pirq_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pin_raw),
      .q    (pin_sync)
   );

   if (HAS_DEBOUNCE) begin : g_deb
      logic [LastPin:0] pin_filt;
      pirq_debounce #(.WIDTH(NPINS)) u_deb (
         .clk  (clk),
         .rst_n(rst_n),
         .tick (deb_tick),
         .d    (pin_sync),
         .filt (pin_filt)
      );
      assign pin_qual = (cfg_deb & pin_filt) | (~cfg_deb & pin_sync);
   end else begin : g_nodeb
      assign pin_qual = pin_sync;
   end

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      pirq_cell u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .q        (pin_qual[i]),
         .en       (cfg_en[i]),
         .edge_mode(cfg_edge[i]),
         .pol      (cfg_pol[i]),
         .eoi      (eoi_clr[i]),
         .pend     (raw_pend[i])
      );
   end

   assign stat = raw_pend & cfg_en & ~cfg_mask;
   assign irq  = |stat;
endmodule

// File: rtl/pirq_chk.sv
module pirq_chk #(
   parameter int NPINS = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NPINS-1:0] cfg_en,
   input logic [NPINS-1:0] cfg_mask,
   input logic [NPINS-1:0] cfg_edge,
   input logic [NPINS-1:0] eoi_clr,
   input logic [NPINS-1:0] raw_pend,
   input logic [NPINS-1:0] stat,
   input logic             irq
);
   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   AST_STAT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
      (stat & ~(raw_pend & ~cfg_mask)) == '0); // R7

   AST_IRQ_FOLLOWS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (stat != '0)); // R8

   AST_DISABLED_EDGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> ((raw_pend & cfg_edge & ~$past(cfg_en)) == '0)); // R6

   AST_EDGE_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (($past(raw_pend & cfg_edge & cfg_en & ~eoi_clr) & $past(cfg_edge)
                  & cfg_edge & cfg_en & ~raw_pend) == '0)); // R3
endmodule

bind pin_irq_unit pirq_chk #(.NPINS(NPINS)) u_pirq_chk (.*);

// File: tb/tb_pin_irq_unit.sv
module tb_pin_irq_unit;
   localparam int N = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] pin_raw = '0;
   logic         deb_tick = 1'b0;
   logic [N-1:0] cfg_en = '0, cfg_mask = '0, cfg_edge = '0, cfg_pol = '0, cfg_deb = '0;
   logic [N-1:0] eoi_clr = '0;
   logic [N-1:0] raw_pend, stat;
   logic         irq;

   int checks = 0;
   int errors = 0;
   int tick_cnt = 0;

   logic [N-1:0] m_prev = '0;
   logic [N-1:0] m_latch = '0;

   always #10 clk = ~clk;

   pin_irq_unit dut (
      .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .deb_tick(deb_tick),
      .cfg_en(cfg_en), .cfg_mask(cfg_mask), .cfg_edge(cfg_edge), .cfg_pol(cfg_pol),
      .cfg_deb(cfg_deb), .eoi_clr(eoi_clr), .raw_pend(raw_pend), .stat(stat), .irq(irq)
   );

   always @(negedge clk) begin
      tick_cnt <= (tick_cnt == 3) ? 0 : tick_cnt + 1;
      deb_tick <= (tick_cnt == 3);
   end

   task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [N-1:0] exp_stat(input logic [N-1:0] rp);
      return rp & cfg_en & ~cfg_mask;
   endfunction

   function automatic logic [N-1:0] exp_raw(input logic [N-1:0] pins);
      return cfg_en & ((cfg_edge & m_latch) | (~cfg_edge & ~(pins ^ cfg_pol)));
   endfunction

   // One settled step: config and clear pulse, then a pin change, then wait
   task automatic step(input string tag, input logic [N-1:0] np, input logic [N-1:0] eoi_v);
      logic [N-1:0] rise, fall, er;
      @(negedge clk);
      eoi_clr = eoi_v;
      @(negedge clk);
      eoi_clr = '0;
      pin_raw = np;
      repeat (16) @(negedge clk);
      m_latch = m_latch & ~eoi_v & cfg_en & cfg_edge;
      rise = np & ~m_prev;
      fall = ~np & m_prev;
      m_latch = m_latch | (cfg_en & cfg_edge & ((cfg_pol & rise) | (~cfg_pol & fall)));
      m_prev = np;
      er = exp_raw(np);
      check({tag, " raw_pend"}, raw_pend, er);
      check({tag, " R8 stat"}, stat, exp_stat(er));
      check({tag, " R8 irq"}, {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, (exp_stat(er) != '0)});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic seen;
      void'($urandom(32'h1234_5eed));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 raw_pend reset", raw_pend, '0);
      check("R1 stat reset", stat, '0);
      check("R1 irq reset", {{(N-1){1'b0}}, irq}, '0);

      // R11 latency: pin0 level active high, no debounce
      cfg_en = 32'h1; cfg_pol = 32'h1;
      @(negedge clk);
      pin_raw[0] = 1'b1;
      @(negedge clk);
      check("R11 after one edge", raw_pend & 32'h1, 32'h0);
      @(negedge clk);
      check("R11 after two edges", raw_pend & 32'h1, 32'h1);
      m_prev[0] = 1'b1;

      // R2 level low on pin1, clear vector ignored
      cfg_en = 32'h3; cfg_pol = 32'h1;
      step("R2 level low", m_prev, '0);
      step("R2 clear ignored", m_prev, '1);
      check("R2 pin1 still pending", raw_pend & 32'h2, 32'h2);

      // R3 edges: pin2 rising, pin3 falling
      cfg_en = 32'h1F; cfg_edge = 32'h1C; cfg_pol = 32'h05;
      step("R3 setup", m_prev | 32'h08, '1);
      step("R3 rise pin2", m_prev | 32'h04, '0);
      check("R3 pin2 latched", raw_pend & 32'h04, 32'h04);
      step("R3 fall pin2 held", m_prev & ~32'h04, '0);
      step("R3 fall pin3", m_prev & ~32'h08, '0);
      check("R3 pin3 latched", raw_pend & 32'h08, 32'h08);

      // R4 selective and full clear
      step("R4 clear pin2", m_prev, 32'h04);
      check("R4 pin3 kept", raw_pend & 32'h0C, 32'h08);
      step("R4 clear all", m_prev, '1);
      check("R4 all edges clear", raw_pend & cfg_edge, '0);

      // R7 masked event still detected
      cfg_mask = 32'h04;
      step("R7 masked rise", m_prev | 32'h04, '0);
      check("R7 raw seen", raw_pend & 32'h04, 32'h04);
      check("R7 stat hidden", stat & 32'h04, '0);
      cfg_mask = '0;
      step("R7 unmask", m_prev, '0);
      check("R7 stat shown", stat & 32'h04, 32'h04);

      // R6 disable clears and stays cleared
      cfg_en = cfg_en & ~32'h04;
      step("R6 disabled", m_prev, '0);
      cfg_en = cfg_en | 32'h04;
      step("R6 re-enabled", m_prev, '0);
      check("R6 no old event", raw_pend & 32'h04, '0);

      // R9 polarity switch keeps a later edge
      cfg_en = cfg_en | 32'h10; cfg_edge = cfg_edge | 32'h10; cfg_pol = cfg_pol & ~32'h10;
      step("R9 falling armed", m_prev & ~32'h10, '1);
      cfg_pol = cfg_pol | 32'h10;
      step("R9 switch to rising", m_prev, '0);
      step("R9 rise", m_prev | 32'h10, '0);
      check("R9 rise caught", raw_pend & 32'h10, 32'h10);

      // R5 set and clear in the same cycle
      cfg_en = cfg_en | 32'h40; cfg_edge = cfg_edge | 32'h40; cfg_pol = cfg_pol | 32'h40;
      step("R5 setup", m_prev & ~32'h40, '0);
      @(negedge clk);
      pin_raw[6] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      eoi_clr = 32'h40;
      @(negedge clk);
      eoi_clr = '0;
      check("R5 set wins", raw_pend & 32'h40, 32'h40);
      m_prev[6] = 1'b1; m_latch[6] = 1'b1;

      // R10 short glitch rejected on a debounced level pin
      cfg_en = cfg_en | 32'h80; cfg_edge = cfg_edge & ~32'h80;
      cfg_pol = cfg_pol | 32'h80; cfg_deb = 32'h80;
      step("R10 setup", m_prev & ~32'h80, '0);
      seen = 1'b0;
      @(negedge clk);
      pin_raw[7] = 1'b1;
      repeat (3) @(negedge clk);
      pin_raw[7] = 1'b0;
      repeat (20) begin
         @(negedge clk);
         seen = seen | raw_pend[7];
      end
      check("R10 glitch ignored", {{(N-1){1'b0}}, seen}, '0);
      step("R10 steady accepted", m_prev | 32'h80, '0);
      check("R10 pin7 pending", raw_pend & 32'h80, 32'h80);

      // Random phase
      for (int s = 0; s < 150; s++) begin
         cfg_en   = $urandom | $urandom;
         cfg_mask = $urandom & $urandom & $urandom;
         cfg_edge = $urandom;
         cfg_pol  = $urandom;
         cfg_deb  = $urandom;
         step("R3 R8 random", m_prev ^ ($urandom & $urandom),
              (($urandom % 4) == 0) ? N'($urandom) : '0);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule